// File: doc/BRIEF.md
# Quantized Row Convolution Processing Element

This block is one processing element of a row-stationary CNN accelerator. It computes a 1-D convolution primitive: one filter row of three taps is slid across one row of an input feature map, and the result is summed over several input channels and several filters. A configuration word is captured when the element is enabled. It sets the operating mode, the number of filters, the number of channels and the number of output positions. The element then takes in weights, activations and incoming partial sums, and it returns outgoing partial sums.

Each of the four data streams has its own valid/ready pair. A word moves only in a cycle where valid and ready are both high. The element exposes exactly one ready, or its output valid, at a time, so the producer sees back-pressure on every channel except the one the element currently wants. An output partial sum stays on the port, with its valid high, until the consumer takes it. No input is accepted while an output is pending.

Activations arrive as uint8 with a zero point of 128. The element removes the zero point by inverting the most significant bit, which yields the signed int8 value directly. Weights are int8 and partial sums are int32. In convolution mode the activation window slides by one column per output position. In fully-connected mode every output position brings a fresh set of activations.

Top module: `pe1d_top`

## Requirements
- R1: A synchronous active-high reset drops `filt_ready`, `ifmap_ready`, `ipsum_ready` and `opsum_valid` to 0 in the cycle after it is sampled, including in the middle of a pass. Afterwards the element is idle, and a following pass produces correct results.
- R2: When idle, a high `pe_en` captures `cfg_in`, and `filt_ready` is high in the next cycle. The fields of `cfg_in` are: bit 0 is the mode (0 convolution, 1 fully-connected); bits [2:1] hold filters−1 (P); bits [4:3] hold channels−1 (Q); bits [12:5] hold output positions−1 (F). While idle with `pe_en` low, all four handshake outputs stay low.
- R3: The weight load takes exactly P·Q·3 words, ordered filter-major, then channel, then tap 0..2 innermost. After the last weight, `filt_ready` falls and `ifmap_ready` rises.
- R4: Each activation byte a is used as the signed int8 value of (a XOR 0x80). For example, 0x00 counts as −128 and 0xFF counts as +127.
- R5: In convolution mode, the first output position loads 3·Q activations, tap-major with channel innermost (columns 0, 1, 2). Each later position loads Q activations, one new column per channel in channel order, and the window shifts by one.
- R6: In fully-connected mode, every output position loads 3·Q activations in the order of R5's first position.
- R7: Each output equals the accepted input partial sum plus the sum, over channels c<Q and taps s<3, of weight(filter,c,s)·activation(c,s). It wraps modulo 2^32.
- R8: While `opsum_valid` is high and `opsum_ready` is low, `opsum_valid` stays high and `opsum_data` stays stable. All input readies stay low during this time.
- R9: Per output position the element asks for one input partial sum per filter, in filter order, and emits one output for each. After F·P outputs it returns to idle.
- R10: No word is taken on any channel unless both its valid and its ready are high. A valid offered on a channel whose ready is low has no effect.
- R11: `pe_en` is ignored while a pass is in progress.
- R12: At most one of `filt_ready`, `ifmap_ready`, `ipsum_ready`, `opsum_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_en | input | 1 | Start a pass; `cfg_in` is valid in the same cycle |
| cfg_in | input | 13 | Configuration word (fields in R2) |
| filt_data | input | 8 | int8 weight |
| filt_valid | input | 1 | Weight valid |
| filt_ready | output | 1 | Weight ready |
| ifmap_data | input | 8 | uint8 activation |
| ifmap_valid | input | 1 | Activation valid |
| ifmap_ready | output | 1 | Activation ready |
| ipsum_data | input | 32 | Incoming int32 partial sum |
| ipsum_valid | input | 1 | Incoming partial sum valid |
| ipsum_ready | output | 1 | Incoming partial sum ready |
| opsum_data | output | 32 | Outgoing int32 partial sum |
| opsum_valid | output | 1 | Outgoing partial sum valid |
| opsum_ready | input | 1 | Outgoing partial sum ready |

## Verification
The properties take for granted that `rst` is applied from time zero for at least one clock. They assume that no configuration ever encodes more filters or channels than the parameters allow; the two-bit fields make that impossible at the default sizes. They also assume that the producer changes data only after a handshake completes. The bench drives every stream from tasks that raise valid at the falling edge and drop it only after a rising edge with ready high. It offers valid on channels that are not ready, and it holds `opsum_ready` low for stretches, so every back-pressure path is exercised within these rules.

// File: rtl/pe1d_pkg.sv
package pe1d_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLOAD,
    ST_XLOAD,
    ST_PSUM,
    ST_EMIT
  } pe_state_t;
endpackage

// File: rtl/pe1d_wspad.sv
// Weight scratchpad: P filters x Q channels x 3 taps, read one filter at a time.
module pe1d_wspad #(
  parameter int MAX_P = 4,
  parameter int MAX_Q = 4,
  parameter int ACT_W = 8,
  localparam int PW    = (MAX_P > 1) ? $clog2(MAX_P) : 1,
  localparam int DEPTH = MAX_P * MAX_Q * 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [AW-1:0]                waddr,
  input  logic [ACT_W-1:0]             wdata,
  input  logic [PW-1:0]                rd_k,
  output logic [MAX_Q*3*ACT_W-1:0]     rd_w
);
  logic [ACT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar c = 0; c < MAX_Q; c++) begin : g_ch
    for (genvar s = 0; s < 3; s++) begin : g_tap
      assign rd_w[(c*3+s)*ACT_W +: ACT_W] = mem[int'(rd_k)*MAX_Q*3 + c*3 + s];
    end
  end
endmodule

// File: rtl/pe1d_xwin.sv
// Per-channel three-tap activation window; zero point removed on write.
module pe1d_xwin #(
  parameter int MAX_Q = 4,
  parameter int ACT_W = 8,
  localparam int QW = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [QW-1:0]            chan,
  input  logic [ACT_W-1:0]         px,
  output logic [MAX_Q*3*ACT_W-1:0] win
);
  logic [ACT_W-1:0] centred;
  assign centred = {~px[ACT_W-1], px[ACT_W-2:0]};

  for (genvar c = 0; c < MAX_Q; c++) begin : g_ch
    logic [ACT_W-1:0] tap0, tap1, tap2;
    always_ff @(posedge clk) begin
      if (rst) begin
        tap0 <= '0;
        tap1 <= '0;
        tap2 <= '0;
      end else if (we && (int'(chan) == c)) begin
        tap0 <= tap1;
        tap1 <= tap2;
        tap2 <= centred;
      end
    end
    assign win[(c*3+0)*ACT_W +: ACT_W] = tap0;
    assign win[(c*3+1)*ACT_W +: ACT_W] = tap1;
    assign win[(c*3+2)*ACT_W +: ACT_W] = tap2;
  end
endmodule

// File: rtl/pe1d_mac.sv
// Dot product of one filter row set with the window, masked to the active channels.
module pe1d_mac #(
  parameter int MAX_Q  = 4,
  parameter int ACT_W  = 8,
  parameter int PSUM_W = 32,
  localparam int QW    = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int SUM_W = 2*ACT_W + $clog2(MAX_Q*3) + 1
) (
  input  logic [MAX_Q*3*ACT_W-1:0] w_flat,
  input  logic [MAX_Q*3*ACT_W-1:0] x_flat,
  input  logic [QW-1:0]            q_m1,
  output logic signed [PSUM_W-1:0] dot
);
  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int c = 0; c < MAX_Q; c++) begin
      for (int s = 0; s < 3; s++) begin
        logic signed [2*ACT_W-1:0] prod;
        prod = $signed(w_flat[(c*3+s)*ACT_W +: ACT_W]) *
               $signed(x_flat[(c*3+s)*ACT_W +: ACT_W]);
        if (c <= int'(q_m1)) acc = acc + SUM_W'(prod);
      end
    end
  end

  assign dot = PSUM_W'(acc);
endmodule

// File: rtl/pe1d_ctrl.sv
// Pass sequencer: config capture, load counters, output ordering.
module pe1d_ctrl
  import pe1d_pkg::*;
#(
  parameter int MAX_P = 4,
  parameter int MAX_Q = 4,
  parameter int FW    = 8,
  localparam int PW    = (MAX_P > 1) ? $clog2(MAX_P) : 1,
  localparam int QW    = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int AW    = $clog2(MAX_P * MAX_Q * 3),
  localparam int CFG_W = 1 + PW + QW + FW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pe_en,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             filt_valid,
  input  logic             ifmap_valid,
  input  logic             ipsum_valid,
  input  logic             opsum_ready,
  output logic             filt_ready,
  output logic             ifmap_ready,
  output logic             ipsum_ready,
  output logic             opsum_valid,
  output logic             w_we,
  output logic [AW-1:0]    w_addr,
  output logic             x_we,
  output logic [QW-1:0]    x_chan,
  output logic [PW-1:0]    rd_k,
  output logic [QW-1:0]    q_m1,
  output logic             acc_load
);
  localparam int P_LO = 1;
  localparam int Q_LO = 1 + PW;
  localparam int F_LO = 1 + PW + QW;

  pe_state_t     state;
  logic          mode_r;
  logic [PW-1:0] pm1_r, f_k, o_k;
  logic [QW-1:0] qm1_r, f_c, i_c;
  logic [FW-1:0] fm1_r, o_x;
  logic [1:0]    f_s, i_s, last_s;

  assign last_s = (!mode_r && (o_x != '0)) ? 2'd0 : 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_r <= 1'b0;
      pm1_r  <= '0;
      qm1_r  <= '0;
      fm1_r  <= '0;
      f_s <= '0; f_c <= '0; f_k <= '0;
      i_s <= '0; i_c <= '0;
      o_k <= '0; o_x <= '0;
    end else begin
      case (state)
        ST_IDLE: if (pe_en) begin
          mode_r <= cfg_in[0];
          pm1_r  <= cfg_in[P_LO +: PW];
          qm1_r  <= cfg_in[Q_LO +: QW];
          fm1_r  <= cfg_in[F_LO +: FW];
          f_s <= '0; f_c <= '0; f_k <= '0;
          i_s <= '0; i_c <= '0;
          o_k <= '0; o_x <= '0;
          state <= ST_WLOAD;
        end
        ST_WLOAD: if (filt_valid) begin
          if (f_s == 2'd2) begin
            f_s <= '0;
            if (f_c == qm1_r) begin
              f_c <= '0;
              if (f_k == pm1_r) begin
                f_k   <= '0;
                state <= ST_XLOAD;
              end else f_k <= f_k + PW'(1);
            end else f_c <= f_c + QW'(1);
          end else f_s <= f_s + 2'd1;
        end
        ST_XLOAD: if (ifmap_valid) begin
          if (i_c == qm1_r) begin
            i_c <= '0;
            if (i_s == last_s) begin
              i_s   <= '0;
              state <= ST_PSUM;
            end else i_s <= i_s + 2'd1;
          end else i_c <= i_c + QW'(1);
        end
        ST_PSUM: if (ipsum_valid) state <= ST_EMIT;
        ST_EMIT: if (opsum_ready) begin
          if (o_k == pm1_r) begin
            o_k <= '0;
            if (o_x == fm1_r) state <= ST_IDLE;
            else begin
              o_x   <= o_x + FW'(1);
              state <= ST_XLOAD;
            end
          end else begin
            o_k   <= o_k + PW'(1);
            state <= ST_PSUM;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign filt_ready  = (state == ST_WLOAD);
  assign ifmap_ready = (state == ST_XLOAD);
  assign ipsum_ready = (state == ST_PSUM);
  assign opsum_valid = (state == ST_EMIT);
  assign w_we        = filt_ready & filt_valid;
  assign w_addr      = AW'((int'(f_k) * MAX_Q + int'(f_c)) * 3 + int'(f_s));
  assign x_we        = ifmap_ready & ifmap_valid;
  assign x_chan      = i_c;
  assign rd_k        = o_k;
  assign q_m1        = qm1_r;
  assign acc_load    = ipsum_ready & ipsum_valid;
endmodule

// File: rtl/pe1d_top.sv
module pe1d_top #(
  parameter int MAX_P  = 4,
  parameter int MAX_Q  = 4,
  parameter int FW     = 8,
  parameter int ACT_W  = 8,
  parameter int PSUM_W = 32,
  localparam int PW    = (MAX_P > 1) ? $clog2(MAX_P) : 1,
  localparam int QW    = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int AW    = $clog2(MAX_P * MAX_Q * 3),
  localparam int CFG_W = 1 + PW + QW + FW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pe_en,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic [ACT_W-1:0]  filt_data,
  input  logic              filt_valid,
  output logic              filt_ready,
  input  logic [ACT_W-1:0]  ifmap_data,
  input  logic              ifmap_valid,
  output logic              ifmap_ready,
  input  logic [PSUM_W-1:0] ipsum_data,
  input  logic              ipsum_valid,
  output logic              ipsum_ready,
  output logic [PSUM_W-1:0] opsum_data,
  output logic              opsum_valid,
  input  logic              opsum_ready
);
  logic                      w_we, x_we, acc_load;
  logic [AW-1:0]             w_addr;
  logic [QW-1:0]             x_chan, q_m1;
  logic [PW-1:0]             rd_k;
  logic [MAX_Q*3*ACT_W-1:0]  w_flat, x_flat;
  logic signed [PSUM_W-1:0]  dot;

  pe1d_ctrl #(.MAX_P(MAX_P), .MAX_Q(MAX_Q), .FW(FW)) u_ctrl (
    .clk(clk), .rst(rst), .pe_en(pe_en), .cfg_in(cfg_in),
    .filt_valid(filt_valid), .ifmap_valid(ifmap_valid),
    .ipsum_valid(ipsum_valid), .opsum_ready(opsum_ready),
    .filt_ready(filt_ready), .ifmap_ready(ifmap_ready),
    .ipsum_ready(ipsum_ready), .opsum_valid(opsum_valid),
    .w_we(w_we), .w_addr(w_addr), .x_we(x_we), .x_chan(x_chan),
    .rd_k(rd_k), .q_m1(q_m1), .acc_load(acc_load)
  );

  pe1d_wspad #(.MAX_P(MAX_P), .MAX_Q(MAX_Q), .ACT_W(ACT_W)) u_wspad (
    .clk(clk), .rst(rst), .we(w_we), .waddr(w_addr), .wdata(filt_data),
    .rd_k(rd_k), .rd_w(w_flat)
  );

  pe1d_xwin #(.MAX_Q(MAX_Q), .ACT_W(ACT_W)) u_xwin (
    .clk(clk), .rst(rst), .we(x_we), .chan(x_chan), .px(ifmap_data),
    .win(x_flat)
  );

  pe1d_mac #(.MAX_Q(MAX_Q), .ACT_W(ACT_W), .PSUM_W(PSUM_W)) u_mac (
    .w_flat(w_flat), .x_flat(x_flat), .q_m1(q_m1), .dot(dot)
  );

  always_ff @(posedge clk) begin
    if (rst)           opsum_data <= '0;
    else if (acc_load) opsum_data <= ipsum_data + dot;
  end
endmodule

// File: rtl/pe1d_chk.sv
module pe1d_chk #(
  parameter int PSUM_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pe_en,
  input logic              filt_valid,
  input logic              filt_ready,
  input logic              ifmap_valid,
  input logic              ifmap_ready,
  input logic              ipsum_valid,
  input logic              ipsum_ready,
  input logic              opsum_valid,
  input logic              opsum_ready,
  input logic [PSUM_W-1:0] opsum_data
);
  logic quiet;
  assign quiet = !(filt_ready || ifmap_ready || ipsum_ready || opsum_valid);

  // R12
  one_channel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({filt_ready, ifmap_ready, ipsum_ready, opsum_valid}));

  // R8
  opsum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opsum_valid && !opsum_ready) |=> (opsum_valid && $stable(opsum_data)));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && pe_en) |=> filt_ready);

  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && !pe_en) |=> quiet);

  // R10
  filt_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_ready && !filt_valid) |=> filt_ready);

  // R10
  ifmap_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ifmap_ready && !ifmap_valid) |=> ifmap_ready);

  // R10
  ipsum_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ipsum_ready && !ipsum_valid) |=> ipsum_ready);

  // R7
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (ipsum_ready && ipsum_valid) |=> opsum_valid);
endmodule

bind pe1d_top pe1d_chk #(.PSUM_W(PSUM_W)) u_chk (
  .clk(clk), .rst(rst), .pe_en(pe_en),
  .filt_valid(filt_valid), .filt_ready(filt_ready),
  .ifmap_valid(ifmap_valid), .ifmap_ready(ifmap_ready),
  .ipsum_valid(ipsum_valid), .ipsum_ready(ipsum_ready),
  .opsum_valid(opsum_valid), .opsum_ready(opsum_ready),
  .opsum_data(opsum_data)
);

// File: tb/pe1d_top_tb.sv
`timescale 1ns/1ps
module pe1d_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pe_en = 1'b0;
  logic [12:0] cfg_in = '0;
  logic [7:0]  filt_data = '0;
  logic        filt_valid = 1'b0;
  logic        filt_ready;
  logic [7:0]  ifmap_data = '0;
  logic        ifmap_valid = 1'b0;
  logic        ifmap_ready;
  logic [31:0] ipsum_data = '0;
  logic        ipsum_valid = 1'b0;
  logic        ipsum_ready;
  logic [31:0] opsum_data;
  logic        opsum_valid;
  logic        opsum_ready = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  int multi_hot = 0;

  always #2.5 clk = ~clk;

  pe1d_top u_dut (
    .clk(clk), .rst(rst), .pe_en(pe_en), .cfg_in(cfg_in),
    .filt_data(filt_data), .filt_valid(filt_valid), .filt_ready(filt_ready),
    .ifmap_data(ifmap_data), .ifmap_valid(ifmap_valid), .ifmap_ready(ifmap_ready),
    .ipsum_data(ipsum_data), .ipsum_valid(ipsum_valid), .ipsum_ready(ipsum_ready),
    .opsum_data(opsum_data), .opsum_valid(opsum_valid), .opsum_ready(opsum_ready)
  );

  // {ipsum base[31:0], stall, pattern[1:0], F-1[7:0], Q-1[1:0], P-1[1:0], mode}
  localparam logic [47:0] VECS [7] = '{
    {32'h0000_0000, 1'b0, 2'd0, 8'd3, 2'd2, 2'd1, 1'b0},
    {32'h0000_0000, 1'b1, 2'd0, 8'd2, 2'd1, 2'd2, 1'b1},
    {32'h0000_0000, 1'b0, 2'd1, 8'd4, 2'd3, 2'd3, 1'b0},
    {32'h0000_0005, 1'b1, 2'd2, 8'd1, 2'd0, 2'd0, 1'b0},
    {32'h7FFF_FFF0, 1'b0, 2'd0, 8'd1, 2'd3, 2'd0, 1'b1},
    {32'h0000_0000, 1'b0, 2'd0, 8'd0, 2'd0, 2'd0, 1'b0},
    {32'hFFFF_FF00, 1'b1, 2'd0, 8'd5, 2'd1, 2'd1, 1'b0}
  };

  always @(negedge clk)
    if (!rst && ($countones({filt_ready, ifmap_ready, ipsum_ready, opsum_valid}) > 1))
      multi_hot++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hsh(input int a);
    return 8'((a * 73 + 29) ^ (a >>> 3));
  endfunction

  function automatic logic [7:0] pix(input int seed, input int pat, input int c, input int j);
    if (pat == 1) return 8'h00;
    if (pat == 2) return 8'hFF;
    return hsh(seed * 1000 + c * 50 + j);
  endfunction

  function automatic logic [7:0] wt(input int seed, input int pat, input int k, input int c, input int s);
    if (pat == 1) return 8'h80;
    if (pat == 2) return 8'h7F;
    return hsh(seed * 777 + k * 31 + c * 7 + s + 500);
  endfunction

  function automatic int actv(input logic [7:0] b);
    logic [7:0] t;
    t = b ^ 8'h80;
    return int'($signed(t));
  endfunction

  function automatic int wval(input logic [7:0] b);
    return int'($signed(b));
  endfunction

  task automatic push_f(input logic [7:0] d, input bit stall);
    if (stall) @(negedge clk);
    filt_data = d; filt_valid = 1'b1;
    while (!filt_ready) @(negedge clk);
    @(negedge clk);
    filt_valid = 1'b0;
  endtask

  task automatic push_x(input logic [7:0] d, input bit stall);
    if (stall) @(negedge clk);
    ifmap_data = d; ifmap_valid = 1'b1;
    while (!ifmap_ready) @(negedge clk);
    @(negedge clk);
    ifmap_valid = 1'b0;
  endtask

  task automatic push_p(input logic [31:0] d, input bit stall);
    if (stall) @(negedge clk);
    ipsum_data = d; ipsum_valid = 1'b1;
    while (!ipsum_ready) @(negedge clk);
    @(negedge clk);
    ipsum_valid = 1'b0;
  endtask

  task automatic pull(input int exp, input bit stall, input string tag);
    logic [31:0] first;
    while (!opsum_valid) @(negedge clk);
    if (stall) begin
      first = opsum_data;
      ipsum_valid = 1'b1;  // offered while an output is pending
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        chk(opsum_valid && (opsum_data == first), "R8", "held output",
            longint'(opsum_data), longint'(first));
        chk(!ipsum_ready && !ifmap_ready && !filt_ready, "R8", "inputs stalled",
            longint'({filt_ready, ifmap_ready, ipsum_ready}), 0);
      end
      ipsum_valid = 1'b0;
    end
    chk(opsum_data == 32'(exp), tag, "opsum", longint'(opsum_data), longint'(32'(exp)));
    opsum_ready = 1'b1;
    @(negedge clk);
    opsum_ready = 1'b0;
  endtask

  task automatic run_pass(input logic [47:0] v, input int seed, input bit inject, input string tag);
    bit          mode, stall;
    int          np, nq, nf, pat, idx, ips, exp;
    logic [31:0] base;
    mode  = v[0];
    np    = int'(v[2:1]) + 1;
    nq    = int'(v[4:3]) + 1;
    nf    = int'(v[12:5]) + 1;
    pat   = int'(v[14:13]);
    stall = v[15];
    base  = v[47:16];
    cfg_in = v[12:0];
    pe_en  = 1'b1;
    @(negedge clk);
    pe_en = 1'b0;
    chk(filt_ready && !ifmap_ready, "R2", "weight load starts",
        longint'({filt_ready, ifmap_ready}), 2);
    if (stall) begin
      ifmap_data = 8'hAA; ifmap_valid = 1'b1;
      chk(!ifmap_ready, "R10", "activation not ready during weight load",
          longint'(ifmap_ready), 0);
    end
    idx = 0;
    for (int k = 0; k < np; k++)
      for (int c = 0; c < nq; c++)
        for (int s = 0; s < 3; s++) begin
          if (inject && idx == 0) begin
            pe_en = 1'b1; cfg_in = ~v[12:0];  // R11: must be ignored
          end
          push_f(wt(seed, pat, k, c, s), stall);
          pe_en = 1'b0; cfg_in = v[12:0];
          idx++;
        end
    ifmap_valid = 1'b0;
    chk(ifmap_ready && !filt_ready, "R3", "weights done",
        longint'({filt_ready, ifmap_ready}), 1);
    for (int x = 0; x < nf; x++) begin
      if (!mode && x > 0) begin
        for (int c = 0; c < nq; c++) push_x(pix(seed, pat, c, x + 2), stall);
      end else begin
        for (int s = 0; s < 3; s++)
          for (int c = 0; c < nq; c++)
            push_x(mode ? pix(seed, pat, c, 64 + x*3 + s) : pix(seed, pat, c, s), stall);
      end
      for (int k = 0; k < np; k++) begin
        ips = int'(base) + x * 16 + k;
        exp = ips;
        for (int c = 0; c < nq; c++)
          for (int s = 0; s < 3; s++)
            exp += wval(wt(seed, pat, k, c, s)) *
                   actv(mode ? pix(seed, pat, c, 64 + x*3 + s) : pix(seed, pat, c, x + s));
        push_p(32'(ips), stall);
        pull(exp, stall, tag);
      end
    end
    for (int i = 0; i < 3; i++) begin
      chk(!filt_ready && !ifmap_ready && !ipsum_ready && !opsum_valid, "R9",
          "idle after pass", longint'({filt_ready, ifmap_ready, ipsum_ready, opsum_valid}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    chk(!filt_ready && !ifmap_ready && !ipsum_ready && !opsum_valid, "R1", "reset outputs",
        longint'({filt_ready, ifmap_ready, ipsum_ready, opsum_valid}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!filt_ready && !ifmap_ready && !ipsum_ready && !opsum_valid, "R2", "idle without enable",
        longint'({filt_ready, ifmap_ready, ipsum_ready, opsum_valid}), 0);

    for (int i = 0; i < 7; i++) begin
      if (VECS[i][14:13] != 2'd0)      tag = "R4";
      else if (VECS[i][47:16] != '0)   tag = "R7";
      else if (VECS[i][0])             tag = "R6";
      else                             tag = "R5";
      run_pass(VECS[i], i + 1, 1'b0, tag);
    end

    // R11: enable pulse during a pass
    run_pass(VECS[0], 9, 1'b1, "R11");

    // R1: reset in the middle of a pass
    cfg_in = VECS[1][12:0]; pe_en = 1'b1;
    @(negedge clk);
    pe_en = 1'b0;
    push_f(8'h11, 1'b0);
    push_f(8'h22, 1'b0);
    ifmap_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(!filt_ready && !ifmap_ready && !ipsum_ready && !opsum_valid, "R1", "mid-pass reset",
        longint'({filt_ready, ifmap_ready, ipsum_ready, opsum_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!filt_ready, "R1", "idle after reset", longint'(filt_ready), 0);
    run_pass(VECS[0], 11, 1'b0, "R1");

    chk(multi_hot == 0, "R12", "single channel active", longint'(multi_hot), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule